// File: doc/BRIEF.md
# Task-File I/O Cycle Decoder

This block sits behind the host pins of a removable-card storage interface running in I/O mode. Every cycle it looks at the host address, the two card-enable strobes, the register-space select and the I/O read and write strobes. It turns a matching cycle into a one-hot read or write select for one of ten disk-controller registers. It also drives byte-lane enables and a data-bus output enable. Two base-address layouts are decoded, and the configuration index picks which one is active.

The data register can be reached in two ways. A 16-bit transfer moves the whole word in one cycle. Two 8-bit transfers on the low lane move the low byte first and the high byte second. The block tracks the read and write directions of these byte pairs separately. It assembles written halves into a word and pulses a strobe with that word. For reads, it presents the low or high half of a supplied read word, depending on which half is due.

Top module: `tf_io_decode`

## Requirements
- R1: A cycle is decoded only when `reg_n` is 0, `cfg_idx` is 2 or 3, and addr[9:4] equals the active base. Index 2 uses 1Fh for the task file and 3Fh for the control block. Index 3 uses 17h and 37h. In every other case no select is asserted and `dout_oe` stays 0.
- R2: Select bit numbering: a task-file read at effective offset k (0..7) asserts `rd_sel[k]`. These are, in order: data, error, sector count, sector number, cylinder low, cylinder high, card/head, status.
- R3: A task-file write at effective offset k (0..7) asserts `wr_sel[k]`. These are, in order: data, feature, sector count, sector number, cylinder low, cylinder high, card/head, command.
- R4: In the control block, offset 6 asserts bit 8 for both reads (alternate status) and writes (device control). A read at offset 7 asserts `rd_sel[9]` (drive address). A write at offset 7, and any other control-block offset, selects nothing.
- R5: With both enables low and addr[3:1]=0 in the task file (A0 ignored), the access is a word access to the data register with `lane_en`=11. A word read drives `host_rdata` = `rd_word_in`. A word write pulses `word_vld` for one cycle with `word_out` = `host_wdata`. The pulse comes in the cycle after the strobe is first seen released.
- R6: With only `ce_lo_n` low, byte writes at task-file offset 0 form pairs on D7..D0 (`lane_en`=01). The first write supplies the low byte and the second the high byte. After the second one is released, `word_vld` pulses with `word_out` = {second, first}.
- R7: With only `ce_lo_n` low, byte reads at task-file offset 0 alternate. `host_rdata[7:0]` carries `rd_word_in[7:0]` on the first read and `rd_word_in[15:8]` on the second, with `host_rdata[15:8]` = 0.
- R8: With only `ce_hi_n` low, the effective offset is {addr[3:1],1} on lane D15..D8 (`lane_en`=10). At offset 0 this reaches the error register (read) or feature register (write).
- R9: With both enables high, no select is asserted, `lane_en` is 00 and `dout_oe` is 0.
- R10: The read-pair and write-pair sequences are independent of each other. Reset clears both. So does any completed word access to the data register and any completed command write, so the next byte access is again a low byte.
- R11: `dout_oe` is 1 exactly during a decoded read. `lane_en` is 00 whenever no select is asserted. `host_rdata` is 0 unless the data register is being read.
- R12: With both enables low at any other decoded offset, the access is a byte access at addr[3:0] on lane D7..D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 10 | Host address A9..A0 |
| ce_lo_n | input | 1 | Low-lane card enable, active low |
| ce_hi_n | input | 1 | High-lane card enable, active low |
| reg_n | input | 1 | Register-space select, active low for I/O |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| cfg_idx | input | 6 | Configuration index |
| host_wdata | input | 16 | Host write data D15..D0 |
| rd_word_in | input | 16 | Current data-register read word |
| rd_sel | output | 10 | One-hot read select |
| wr_sel | output | 10 | One-hot write select |
| lane_en | output | 2 | Byte lanes in use, bit 0 = D7..D0, bit 1 = D15..D8 |
| dout_oe | output | 1 | Data-bus output enable |
| host_rdata | output | 16 | Data-register read data toward the host |
| word_out | output | 16 | Assembled write word |
| word_vld | output | 1 | One-cycle strobe for `word_out` |

## Verification
The assertions assume that the host never drives both I/O strobes low together. They also assume that address, enables and write data stay stable while a strobe is low, and that at least one idle cycle separates two accesses. The stimulus drives every access through a single task. That task sets all inputs before lowering one strobe, holds them for a chosen number of cycles, and raises the strobe before the enables are released. It then leaves an idle cycle. Under these conditions each completed access produces exactly one sequencing step, and a new word strobe can never follow the previous one directly.

// File: rtl/tf_pkg.sv
// Shared constants and types for the task-file I/O decoder.
// Assumes ten register slots: eight task-file offsets and two control-block ones.
package tf_pkg;
    localparam int NREG     = 10;
    localparam int IDX_W    = $clog2(NREG);
    localparam int IDX_DATA = 0;
    localparam int IDX_CMD  = 7;
    localparam int IDX_ALT  = 8;
    localparam int IDX_DRV  = 9;
    localparam int OFF_W    = 4;

    typedef enum logic [1:0] {
        LANE_NONE = 2'b00,
        LANE_LO   = 2'b01,
        LANE_HI   = 2'b10,
        LANE_BOTH = 2'b11
    } lane_t;

    // Summary of the access in progress that the sequencing logic needs
    typedef struct packed {
        logic rd;
        logic data_word;
        logic data_byte;
        logic cmd_wr;
    } acc_t;
endpackage

// File: rtl/tf_addr_decode.sv
// Combinational decode of one host I/O cycle into register selects and lanes.
// Assumes: address, enables and data are stable while a strobe is low, and the
// two strobes are never low together (such a cycle is treated as no access).
module tf_addr_decode
    import tf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CFG_W  = 6,
    parameter int unsigned CFG_PRI = 2,
    parameter int unsigned CFG_SEC = 3,
    parameter logic [ADDR_W-OFF_W-1:0] TF_BASE_PRI = 'h1F,
    parameter logic [ADDR_W-OFF_W-1:0] CB_BASE_PRI = 'h3F,
    parameter logic [ADDR_W-OFF_W-1:0] TF_BASE_SEC = 'h17,
    parameter logic [ADDR_W-OFF_W-1:0] CB_BASE_SEC = 'h37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_lo_n,
    input  logic              ce_hi_n,
    input  logic              reg_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic [CFG_W-1:0]  cfg_idx,
    output logic [NREG-1:0]   rd_sel,
    output logic [NREG-1:0]   wr_sel,
    output logic [1:0]        lane_en,
    output logic              dout_oe,
    output acc_t              acc
);
    localparam int BASE_W = ADDR_W - OFF_W;

    logic              is_rd, is_wr, cfg_ok, hit_tf, hit_cb;
    logic [BASE_W-1:0] base_tf, base_cb;
    logic [OFF_W-1:0]  off;
    logic              word_acc, idx_ok, rd_only;
    lane_t             lane;
    logic [IDX_W-1:0]  idx;

    // Direction and base-address match for the active configuration
    always_comb begin
        is_rd   = !iord_n && iowr_n;
        is_wr   = !iowr_n && iord_n;
        cfg_ok  = (cfg_idx == CFG_W'(CFG_PRI)) || (cfg_idx == CFG_W'(CFG_SEC));
        base_tf = (cfg_idx == CFG_W'(CFG_SEC)) ? TF_BASE_SEC : TF_BASE_PRI;
        base_cb = (cfg_idx == CFG_W'(CFG_SEC)) ? CB_BASE_SEC : CB_BASE_PRI;
        hit_tf  = cfg_ok && !reg_n && (addr[ADDR_W-1:OFF_W] == base_tf);
        hit_cb  = cfg_ok && !reg_n && (addr[ADDR_W-1:OFF_W] == base_cb);
    end

    // Access width, lane and effective offset from the two card enables
    always_comb begin
        word_acc = 1'b0;
        off      = addr[OFF_W-1:0];
        lane     = LANE_NONE;
        case ({ce_hi_n, ce_lo_n})
            2'b00: begin
                if (hit_tf && addr[OFF_W-1:1] == '0) begin
                    word_acc = 1'b1;
                    off      = '0;
                    lane     = LANE_BOTH;
                end else begin
                    lane = LANE_LO;
                end
            end
            2'b10:   lane = LANE_LO;
            2'b01: begin
                off  = {addr[OFF_W-1:1], 1'b1};
                lane = LANE_HI;
            end
            default: lane = LANE_NONE;
        endcase
    end

    // Register slot from block and effective offset
    always_comb begin
        idx_ok  = 1'b0;
        rd_only = 1'b0;
        idx     = '0;
        if (lane != LANE_NONE) begin
            if (hit_tf && !off[OFF_W-1]) begin
                idx_ok = 1'b1;
                idx    = IDX_W'(off[OFF_W-2:0]);
            end else if (hit_cb && off == OFF_W'(6)) begin
                idx_ok = 1'b1;
                idx    = IDX_W'(IDX_ALT);
            end else if (hit_cb && off == OFF_W'(7)) begin
                idx_ok  = 1'b1;
                rd_only = 1'b1;
                idx     = IDX_W'(IDX_DRV);
            end
        end
    end

    // One select line per register slot
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign rd_sel[g] = is_rd && idx_ok && (idx == IDX_W'(g));
        assign wr_sel[g] = is_wr && idx_ok && !rd_only && (idx == IDX_W'(g));
    end

    // Lane enables, output enable and access summary
    always_comb begin
        lane_en       = ((|rd_sel) || (|wr_sel)) ? lane : LANE_NONE;
        dout_oe       = |rd_sel;
        acc.rd        = is_rd;
        acc.data_word = word_acc && (rd_sel[IDX_DATA] || wr_sel[IDX_DATA]);
        acc.data_byte = !word_acc && (rd_sel[IDX_DATA] || wr_sel[IDX_DATA]);
        acc.cmd_wr    = wr_sel[IDX_CMD];
    end

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_sel, wr_sel}));
    p_rsvd_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && hit_cb && off == OFF_W'(7)) |-> (wr_sel == '0));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n && ce_hi_n) |-> (rd_sel == '0 && wr_sel == '0 && !dout_oe && lane_en == 2'b00));
    p_oe_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!iord_n && iowr_n));
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!iord_n && !iowr_n));
endmodule

// File: rtl/tf_access_track.sv
// Remembers the last active cycle of an I/O access and flags its completion.
// Assumes at least one idle cycle between accesses, so one access gives one commit.
module tf_access_track
    import tf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iord_n,
    input  logic          iowr_n,
    input  acc_t          acc,
    input  logic [DW-1:0] wdata,
    output logic          commit,
    output acc_t          snap_acc,
    output logic [DW-1:0] snap_wdata
);
    logic act_q;
    logic act_now;

    assign act_now = !iord_n || !iowr_n;
    assign commit  = act_q && !act_now;

    // Capture the access summary and write data on every active cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            snap_acc   <= '0;
            snap_wdata <= '0;
        end else begin
            act_q <= act_now;
            if (act_now) begin
                snap_acc   <= acc;
                snap_wdata <= wdata;
            end
        end
    end

    p_commit_after_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!iord_n || !iowr_n));
endmodule

// File: rtl/tf_pair_seq.sv
// Byte-pair sequencing for the data register: separate read and write half
// toggles, write-word assembly and read-half steering.
// Assumes commit is a single-cycle pulse at the end of each access.
module tf_pair_seq
    import tf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  acc_t          snap_acc,
    input  logic [DW-1:0] snap_wdata,
    input  logic          cur_rd,
    input  logic          cur_word,
    input  logic          cur_byte,
    input  logic [DW-1:0] rd_word_in,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] word_out,
    output logic          word_vld
);
    localparam int HW = DW / 2;

    logic          rd_odd_q, wr_odd_q;
    logic [HW-1:0] even_q;

    // Advance toggles and assemble words when an access completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_odd_q <= 1'b0;
            wr_odd_q <= 1'b0;
            even_q   <= '0;
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (commit) begin
                if (snap_acc.data_word || snap_acc.cmd_wr) begin
                    rd_odd_q <= 1'b0;
                    wr_odd_q <= 1'b0;
                    if (snap_acc.data_word && !snap_acc.rd) begin
                        word_out <= snap_wdata;
                        word_vld <= 1'b1;
                    end
                end else if (snap_acc.data_byte) begin
                    if (snap_acc.rd) begin
                        rd_odd_q <= !rd_odd_q;
                    end else if (!wr_odd_q) begin
                        even_q   <= snap_wdata[HW-1:0];
                        wr_odd_q <= 1'b1;
                    end else begin
                        word_out <= {snap_wdata[HW-1:0], even_q};
                        word_vld <= 1'b1;
                        wr_odd_q <= 1'b0;
                    end
                end
            end
        end
    end

    // Steer the data-register read word or the due half onto the host bus
    always_comb begin
        host_rdata = '0;
        if (cur_rd && cur_word) begin
            host_rdata = rd_word_in;
        end else if (cur_rd && cur_byte) begin
            host_rdata = {{HW{1'b0}}, rd_odd_q ? rd_word_in[DW-1:HW] : rd_word_in[HW-1:0]};
        end
    end

    p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    p_vld_from_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(commit));
    p_rdata_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_rd && cur_byte) |-> (host_rdata[DW-1:HW] == '0));
endmodule

// File: rtl/tf_io_decode.sv
// Top level of the task-file I/O decoder: address decode, access tracking and
// data-register byte-pair sequencing.
// Assumes the host keeps inputs stable during a strobe and idles between accesses.
module tf_io_decode
    import tf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CFG_W  = 6,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_lo_n,
    input  logic              ce_hi_n,
    input  logic              reg_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic [CFG_W-1:0]  cfg_idx,
    input  logic [DW-1:0]     host_wdata,
    input  logic [DW-1:0]     rd_word_in,
    output logic [NREG-1:0]   rd_sel,
    output logic [NREG-1:0]   wr_sel,
    output logic [1:0]        lane_en,
    output logic              dout_oe,
    output logic [DW-1:0]     host_rdata,
    output logic [DW-1:0]     word_out,
    output logic              word_vld
);
    acc_t          acc, snap_acc;
    logic          commit;
    logic [DW-1:0] snap_wdata;

    tf_addr_decode #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
        .reg_n(reg_n), .iord_n(iord_n), .iowr_n(iowr_n), .cfg_idx(cfg_idx),
        .rd_sel(rd_sel), .wr_sel(wr_sel), .lane_en(lane_en), .dout_oe(dout_oe), .acc(acc)
    );

    tf_access_track #(.DW(DW)) u_trk (
        .clk(clk), .rst_n(rst_n), .iord_n(iord_n), .iowr_n(iowr_n), .acc(acc),
        .wdata(host_wdata), .commit(commit), .snap_acc(snap_acc), .snap_wdata(snap_wdata)
    );

    tf_pair_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .commit(commit), .snap_acc(snap_acc),
        .snap_wdata(snap_wdata), .cur_rd(acc.rd), .cur_word(acc.data_word),
        .cur_byte(acc.data_byte), .rd_word_in(rd_word_in), .host_rdata(host_rdata),
        .word_out(word_out), .word_vld(word_vld)
    );

    p_nosel_no_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == '0 && wr_sel == '0) |-> (lane_en == 2'b00 && !dout_oe));
    p_bad_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx != CFG_W'(2) && cfg_idx != CFG_W'(3)) |-> (rd_sel == '0 && wr_sel == '0));
endmodule

// File: tb/test_tf_io_decode.sv
`timescale 1ns/1ps
module test_tf_io_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic        ce_lo_n = 1'b1, ce_hi_n = 1'b1, reg_n = 1'b0;
    logic        iord_n = 1'b1, iowr_n = 1'b1;
    logic [5:0]  cfg_idx = 6'd2;
    logic [15:0] host_wdata = '0, rd_word_in = 16'hA55C;
    logic [9:0]  rd_sel, wr_sel;
    logic [1:0]  lane_en;
    logic        dout_oe, word_vld;
    logic [15:0] host_rdata, word_out;

    int    checks = 0, failures = 0;
    string cur_req = "R10";
    bit    run = 1'b0, done = 1'b0;
    int    rd_ph = 0, wr_ph = 0;
    logic [7:0]  even_b = '0;
    bit          exp_vld = 1'b0;
    logic [15:0] exp_word = '0;

    always #2 clk = ~clk;

    tf_io_decode i_tf_io_decode (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
        .reg_n(reg_n), .iord_n(iord_n), .iowr_n(iowr_n), .cfg_idx(cfg_idx),
        .host_wdata(host_wdata), .rd_word_in(rd_word_in), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .lane_en(lane_en), .dout_oe(dout_oe), .host_rdata(host_rdata),
        .word_out(word_out), .word_vld(word_vld)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    // Behavioural expectation of the combinational outputs from the requirements
    task automatic model(output logic [9:0] rs, output logic [9:0] ws, output logic [1:0] ln,
                         output logic oe, output logic [15:0] hr, output int idx, output bit wacc);
        bit rd, wr, tf, cb;
        int tfb, cbb, off;
        rs = '0; ws = '0; ln = 2'b00; oe = 1'b0; hr = '0; idx = -1; wacc = 1'b0;
        rd = !iord_n && iowr_n;
        wr = !iowr_n && iord_n;
        if (cfg_idx == 6'd2) begin tfb = 'h1F; cbb = 'h3F; end
        else if (cfg_idx == 6'd3) begin tfb = 'h17; cbb = 'h37; end
        else begin tfb = -1; cbb = -1; end
        tf = !reg_n && (int'(addr[9:4]) == tfb);
        cb = !reg_n && (int'(addr[9:4]) == cbb);
        if (!(rd || wr) || (ce_lo_n && ce_hi_n)) return;
        if (!ce_lo_n && !ce_hi_n && tf && addr[3:1] == 3'b000) begin
            off = 0; ln = 2'b11; wacc = 1'b1;
        end else if (!ce_lo_n) begin
            off = int'(addr[3:0]); ln = 2'b01;
        end else begin
            off = int'({addr[3:1], 1'b1}); ln = 2'b10;
        end
        if (tf && off < 8) idx = off;
        else if (cb && off == 6) idx = 8;
        else if (cb && off == 7 && rd) idx = 9;
        if (idx < 0) begin
            ln = 2'b00; wacc = 1'b0;
            return;
        end
        if (rd) begin
            rs[idx] = 1'b1;
            oe = 1'b1;
            if (idx == 0)
                hr = wacc ? rd_word_in : {8'h00, (rd_ph != 0) ? rd_word_in[15:8] : rd_word_in[7:0]};
        end else begin
            ws[idx] = 1'b1;
        end
    endtask

    // Compare every output with the model once per clock, after the edge
    always @(posedge clk) begin
        logic [9:0] rs, ws; logic [1:0] ln; logic oe; logic [15:0] hr; int idx; bit w;
        #1;
        if (rst_n && run) begin
            model(rs, ws, ln, oe, hr, idx, w);
            chk("rd_sel", 16'(rd_sel), 16'(rs));
            chk("wr_sel", 16'(wr_sel), 16'(ws));
            chk("lane_en", 16'(lane_en), 16'(ln));
            chk("dout_oe", 16'(dout_oe), 16'(oe));
            chk("host_rdata", host_rdata, hr);
            chk("word_vld", 16'(word_vld), 16'(exp_vld));
            if (exp_vld) chk("word_out", word_out, exp_word);
            exp_vld = 1'b0;
        end
    end

    // One host access: set up, hold the strobe, update the model, release
    task automatic access(input bit rd, input logic [9:0] a, input bit lo_n, input bit hi_n,
                          input logic [15:0] wd, input int hold);
        logic [9:0] rs, ws; logic [1:0] ln; logic oe; logic [15:0] hr; int idx; bit w;
        @(negedge clk);
        addr = a; ce_lo_n = lo_n; ce_hi_n = hi_n; host_wdata = wd;
        if (rd) iord_n = 1'b0; else iowr_n = 1'b0;
        repeat (hold) @(negedge clk);
        model(rs, ws, ln, oe, hr, idx, w);
        if (idx == 0) begin
            if (w) begin
                rd_ph = 0; wr_ph = 0;
                if (!rd) begin exp_word = wd; exp_vld = 1'b1; end
            end else if (rd) begin
                rd_ph ^= 1;
            end else if (wr_ph == 0) begin
                even_b = wd[7:0]; wr_ph = 1;
            end else begin
                exp_word = {wd[7:0], even_b}; exp_vld = 1'b1; wr_ph = 0;
            end
        end else if (idx == 7 && !rd) begin
            rd_ph = 0; wr_ph = 0;
        end
        iord_n = 1'b1; iowr_n = 1'b1;
        @(negedge clk);
        ce_lo_n = 1'b1; ce_hi_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10";   // reset state
        chk("reset word_vld", 16'(word_vld), 16'h0);
        chk("reset word_out", word_out, 16'h0);
        chk("reset host_rdata", host_rdata, 16'h0);
        rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk);

        cur_req = "R2";
        for (int k = 1; k < 8; k++) access(1'b1, 10'h1F0 + 10'(k), 1'b0, 1'b1, 16'h0, 2);
        cur_req = "R3";
        for (int k = 1; k < 8; k++) access(1'b0, 10'h1F0 + 10'(k), 1'b0, 1'b1, 16'h1100 + 16'(k), 1);
        cur_req = "R4";
        access(1'b1, 10'h3F6, 1'b0, 1'b1, 16'h0, 1);
        access(1'b0, 10'h3F6, 1'b0, 1'b1, 16'h0004, 1);
        access(1'b1, 10'h3F7, 1'b0, 1'b1, 16'h0, 1);
        access(1'b0, 10'h3F7, 1'b0, 1'b1, 16'h0, 2);
        access(1'b1, 10'h3F5, 1'b0, 1'b1, 16'h0, 1);
        cur_req = "R1";
        cfg_idx = 6'd3;
        for (int k = 1; k < 8; k++) access(1'b1, 10'h170 + 10'(k), 1'b0, 1'b1, 16'h0, 1);
        access(1'b0, 10'h376, 1'b0, 1'b1, 16'h0, 1);
        access(1'b1, 10'h1F2, 1'b0, 1'b1, 16'h0, 1);
        cfg_idx = 6'd1;
        access(1'b1, 10'h1F2, 1'b0, 1'b1, 16'h0, 1);
        cfg_idx = 6'd2;
        reg_n = 1'b1;
        access(1'b1, 10'h1F3, 1'b0, 1'b1, 16'h0, 1);
        reg_n = 1'b0;
        cur_req = "R5";
        access(1'b0, 10'h1F0, 1'b0, 1'b0, 16'hBEEF, 1);
        access(1'b0, 10'h1F1, 1'b0, 1'b0, 16'h1234, 3);
        access(1'b1, 10'h1F1, 1'b0, 1'b0, 16'h0, 2);
        cur_req = "R6";
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h00AB, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h00CD, 2);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0011, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0022, 1);
        cur_req = "R7";
        rd_word_in = 16'h7E81;
        for (int k = 0; k < 4; k++) access(1'b1, 10'h1F0, 1'b0, 1'b1, 16'h0, 2);
        cur_req = "R10";
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0033, 1);
        access(1'b1, 10'h1F0, 1'b0, 1'b1, 16'h0, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0044, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0055, 1);
        access(1'b1, 10'h1F0, 1'b0, 1'b0, 16'h0, 1);
        access(1'b1, 10'h1F0, 1'b0, 1'b1, 16'h0, 1);
        access(1'b0, 10'h1F7, 1'b0, 1'b1, 16'h0020, 1);
        access(1'b1, 10'h1F0, 1'b0, 1'b1, 16'h0, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0066, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b0, 16'h5A5A, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0077, 1);
        access(1'b0, 10'h1F0, 1'b0, 1'b1, 16'h0088, 1);
        cur_req = "R8";
        access(1'b1, 10'h1F0, 1'b1, 1'b0, 16'h0, 1);
        access(1'b0, 10'h1F0, 1'b1, 1'b0, 16'h0300, 1);
        access(1'b1, 10'h1F2, 1'b1, 1'b0, 16'h0, 1);
        access(1'b1, 10'h3F6, 1'b1, 1'b0, 16'h0, 1);
        cur_req = "R9";
        access(1'b1, 10'h1F0, 1'b1, 1'b1, 16'h0, 1);
        access(1'b0, 10'h1F3, 1'b1, 1'b1, 16'h0, 1);
        cur_req = "R12";
        access(1'b1, 10'h1F3, 1'b0, 1'b0, 16'h0, 1);
        access(1'b0, 10'h1F4, 1'b0, 1'b0, 16'h0, 1);
        access(1'b1, 10'h3F6, 1'b0, 1'b0, 16'h0, 1);
        cur_req = "R11";
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule